// File: doc/BRIEF.md
# Banked Interrupt Request Aggregator

This block gathers up to twenty-four peripheral interrupt requests into a single active-high interrupt line for a host processor. The host detects that line on its rising edge. It then reads the block over a simple byte-wide register port to find out which sources need service. The sources are split into banks of eight. Each bank has one status byte and one mask byte. The host sees a source as pending when its status bit and its mask bit are both 1.

Every source except one is edge-sensitive. Its input is synchronized, a rising edge is detected, and the edge is latched only while the source is enabled. A latched edge is acknowledged by reading the status byte that holds it, so no acknowledge write exists. One source, chosen by a parameter, is level-sensitive: its status bit shows the synchronized input level. Because a read of a status byte can leave other sources pending, the output is pulled low for one cycle after every status read. This gives the host a fresh rising edge if work remains.

Top module: `irq_collect_top`

## Requirements
- R1: After a synchronous active-low reset, every mask bit is 0, every edge latch is 0, and `irq_o` and `rd_data` are 0.
- R2: Offsets 0, 1 and 2 read the status bytes, and offsets 3, 4 and 5 read and write the mask bytes. Source i appears at bit i mod 8 of status offset i/8 and of mask offset 3 + i/8. Offsets 6 and 7 read as 0 and ignore writes. `rd_data` is loaded on the clock edge that samples `rd_en` and holds its value until the next read.
- R3: An edge source's input passes through a two-stage synchronizer. A rising edge on that input sets its status latch when the mask bit is 1. The latch is set on the third clock edge after the input changes.
- R4: A rising edge on an edge source whose mask bit is 0 is not latched. Setting the mask bit afterwards shows a 0 status bit and raises no interrupt.
- R5: Reading a status byte returns the value from before the read. The read then clears the edge latches of that byte only, and the other banks keep their latches.
- R6: An edge that would be latched on the same clock edge as a read of its status byte stays latched. The next read of that byte returns it.
- R7: The level source (index 12 by default) shows the synchronized input level in its status bit. A read does not clear it, and it reads back whatever its mask bit is.
- R8: `irq_o` is a registered signal. It is 1 in the cycle after any status bit whose mask bit is 1 is set. For an edge source this is the fourth clock edge after the input changes.
- R9: A read of any status byte forces `irq_o` to 0 for the following cycle. If a masked status bit is still set, `irq_o` returns to 1 in the cycle after that.
- R10: Clearing a mask bit removes its source from `irq_o` but keeps the edge latch. Setting the mask bit again brings the interrupt back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 24 | Raw interrupt request inputs, one per source |
| rd_en | input | 1 | Read strobe for the register port |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| irq_o | output | 1 | Combined interrupt request to the host |

## Verification
The assertions assume the following about the inputs: `src_i` may change at any time relative to the bus, reads and writes may share a cycle, and a read may target any offset, including unused ones. The stimulus holds each source level for several cycles and drives every input away from the sampling edge, so each change passes cleanly through the synchronizer. It deliberately times one read to land on the same edge as a latching edge. A pseudo-random phase then mixes source toggles with reads and writes at every offset. A behavioural model follows it clock by clock, so the masked-drop, read-clear and output-drop rules are exercised in many overlapping combinations.

// File: rtl/irq_agg_pkg.sv
// Shared definitions for the interrupt aggregator.
// Assumes the register map places the status bytes at the lowest offsets,
// followed by the mask bytes, with any remaining offsets left unused.
package irq_agg_pkg;

    typedef enum logic [1:0] {
        ACC_STATUS = 2'd0,
        ACC_MASK   = 2'd1,
        ACC_VOID   = 2'd2
    } acc_kind_e;

    // Classify a register offset for a block with nb banks.
    function automatic acc_kind_e classify(input int unsigned off, input int unsigned nb);
        if (off < nb)
            return ACC_STATUS;
        else if (off < 2 * nb)
            return ACC_MASK;
        else
            return ACC_VOID;
    endfunction

endpackage

// File: rtl/irq_src_sync.sv
// Input conditioning for every interrupt source.
// Each source passes through a STAGES-deep synchronizer. Edge sources then
// give a one-cycle pulse on a rising edge; the level source gives the
// synchronized level itself. Assumes STAGES >= 2 and asynchronous inputs.
module irq_src_sync #(
    parameter int N         = 24,
    parameter int STAGES    = 2,
    parameter int LEVEL_SRC = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    output logic [N-1:0] evt_o
);

    for (genvar gi = 0; gi < N; gi++) begin : g_src
        logic [STAGES-1:0] ch_q;

        // Shift the raw input through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ch_q <= '0;
            else
                ch_q <= {ch_q[STAGES-2:0], src_i[gi]};
        end

        if (gi == LEVEL_SRC) begin : g_lvl
            assign evt_o[gi] = ch_q[STAGES-1];
        end else begin : g_edge
            logic prev_q;

            // Hold the previous synchronized value for edge detection.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    prev_q <= 1'b0;
                else
                    prev_q <= ch_q[STAGES-1];
            end

            assign evt_o[gi] = ch_q[STAGES-1] & ~prev_q;
        end
    end

endmodule

// File: rtl/irq_bank_latch.sv
// One bank of W sources: the mask register, the edge latches and the
// status byte. For edge positions evt_i is a rising-edge pulse. At the
// level position (global index LEVEL_SRC) it is the synchronized level.
// A clear strobe drops all edge latches of the bank, but an edge that
// is latching in the same cycle wins.
module irq_bank_latch #(
    parameter int W         = 8,
    parameter int BASE      = 0,
    parameter int LEVEL_SRC = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         clr_i,
    input  logic         mask_we_i,
    input  logic [W-1:0] mask_wdata_i,
    output logic [W-1:0] status_o,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] edge_o,
    output logic [W-1:0] set_o,
    output logic         pend_o
);

    logic [W-1:0] mask_q;

    // Mask register: loaded by a write to this bank's mask offset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (mask_we_i)
            mask_q <= mask_wdata_i;
    end

    for (genvar gb = 0; gb < W; gb++) begin : g_bit
        if (BASE + gb == LEVEL_SRC) begin : g_lvl
            assign status_o[gb] = evt_i[gb];
            assign edge_o[gb]   = 1'b0;
            assign set_o[gb]    = 1'b0;
        end else begin : g_edge
            logic lat_q;
            logic set_w;

            assign set_w = evt_i[gb] & mask_q[gb];

            // Edge latch: set by an enabled edge, cleared by a status read.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    lat_q <= 1'b0;
                else
                    lat_q <= (lat_q & ~clr_i) | set_w;
            end

            assign status_o[gb] = lat_q;
            assign edge_o[gb]   = lat_q;
            assign set_o[gb]    = set_w;
        end
    end

    assign mask_o = mask_q;
    assign pend_o = |(status_o & mask_q);

endmodule

// File: rtl/irq_reg_port.sv
// Byte-wide register port. It decodes the read and write strobes into
// per-bank clear and mask-write strobes, and registers the read data.
// Assumes the status bytes sit at offsets 0..NB-1 and the mask bytes at
// NB..2*NB-1.
module irq_reg_port
    import irq_agg_pkg::*;
#(
    parameter int NB = 3,
    parameter int W  = 8,
    parameter int AW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_en,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [NB*W-1:0] status_i,
    input  logic [NB*W-1:0] mask_i,
    output logic [NB-1:0]   clr_o,
    output logic [NB-1:0]   mask_we_o,
    output logic            stat_rd_o,
    output logic [W-1:0]    rd_data
);

    logic [W-1:0] rd_next;
    logic [W-1:0] rd_q;
    acc_kind_e    kind;

    assign kind      = classify(32'(addr), NB);
    assign stat_rd_o = rd_en && (kind == ACC_STATUS);

    for (genvar gb = 0; gb < NB; gb++) begin : g_dec
        assign clr_o[gb]     = stat_rd_o && (addr == AW'(gb));
        assign mask_we_o[gb] = wr_en && (addr == AW'(NB + gb));
    end

    // Select the byte addressed by the current offset.
    always_comb begin
        rd_next = '0;
        for (int b = 0; b < NB; b++) begin
            if (kind == ACC_STATUS && addr == AW'(b))
                rd_next = status_i[b*W +: W];
            if (kind == ACC_MASK && addr == AW'(NB + b))
                rd_next = mask_i[b*W +: W];
        end
    end

    // Read data register: loaded on each read strobe, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else if (rd_en)
            rd_q <= rd_next;
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/irq_collect_top.sv
// Interrupt aggregator top. It synchronizes NB*W request inputs, latches
// enabled edges per bank, keeps one level source live, and drives a single
// registered interrupt line. The line drops for one cycle after any status
// read so the host sees a new rising edge if requests remain.
// Assumes the host reacts to the rising edge of irq_o.
module irq_collect_top #(
    parameter int NB          = 3,
    parameter int W           = 8,
    parameter int AW          = 3,
    parameter int LEVEL_SRC   = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NB*W-1:0] src_i,
    input  logic            rd_en,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [W-1:0]    wdata,
    output logic [W-1:0]    rd_data,
    output logic            irq_o
);

    localparam int N = NB * W;

    logic [N-1:0]  evt;
    logic [N-1:0]  status_all;
    logic [N-1:0]  mask_q;
    logic [N-1:0]  edge_stat_q;
    logic [N-1:0]  edge_set;
    logic [NB-1:0] pend;
    logic [NB-1:0] clr;
    logic [NB-1:0] mask_we;
    logic          stat_rd;
    logic          irq_q;

    irq_src_sync #(
        .N         (N),
        .STAGES    (SYNC_STAGES),
        .LEVEL_SRC (LEVEL_SRC)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .src_i (src_i),
        .evt_o (evt)
    );

    for (genvar gb = 0; gb < NB; gb++) begin : g_bank
        irq_bank_latch #(
            .W         (W),
            .BASE      (gb * W),
            .LEVEL_SRC (LEVEL_SRC)
        ) u_bank (
            .clk          (clk),
            .rst_n        (rst_n),
            .evt_i        (evt[gb*W +: W]),
            .clr_i        (clr[gb]),
            .mask_we_i    (mask_we[gb]),
            .mask_wdata_i (wdata),
            .status_o     (status_all[gb*W +: W]),
            .mask_o       (mask_q[gb*W +: W]),
            .edge_o       (edge_stat_q[gb*W +: W]),
            .set_o        (edge_set[gb*W +: W]),
            .pend_o       (pend[gb])
        );
    end

    irq_reg_port #(
        .NB (NB),
        .W  (W),
        .AW (AW)
    ) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .addr      (addr),
        .status_i  (status_all),
        .mask_i    (mask_q),
        .clr_o     (clr),
        .mask_we_o (mask_we),
        .stat_rd_o (stat_rd),
        .rd_data   (rd_data)
    );

    // Output register: any masked pending bit, dropped after a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= (|pend) & ~stat_rd;
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/irq_collect_chk.sv
// Property checker for irq_collect_top, attached by bind below.
// Assumes nothing about when the inputs change. Every property waits one
// cycle after reset so that $past never reaches into the reset phase.
module irq_collect_chk #(
    parameter int NB = 3,
    parameter int W  = 8,
    parameter int AW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rd_en,
    input logic [AW-1:0]   addr,
    input logic            irq_o,
    input logic [NB*W-1:0] mask_q,
    input logic [NB*W-1:0] status_all,
    input logic [NB*W-1:0] edge_stat_q,
    input logic [NB*W-1:0] edge_set
);

    logic past_ok;

    // Mark the cycles where one clean post-reset sample exists.
    always_ff @(posedge clk) begin
        if (!rst_n)
            past_ok <= 1'b0;
        else
            past_ok <= 1'b1;
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask_q == '0 && edge_stat_q == '0 && !irq_o));

    p_masked_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((edge_stat_q & ~$past(edge_stat_q) & ~$past(mask_q)) == '0));

    p_edge_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (($past(edge_set) & ~edge_stat_q) == '0));

    p_irq_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !(rd_en && addr < AW'(NB))) |=>
            (irq_o == |($past(status_all & mask_q))));

    p_read_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && rd_en && addr < AW'(NB)) |=> !irq_o);

    for (genvar gb = 0; gb < NB; gb++) begin : g_clr
        p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && rd_en && addr == AW'(gb)) |=>
                ((edge_stat_q[gb*W +: W] & ~$past(edge_set[gb*W +: W])) == '0));
    end

endmodule

bind irq_collect_top irq_collect_chk #(
    .NB (NB),
    .W  (W),
    .AW (AW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (rd_en),
    .addr        (addr),
    .irq_o       (irq_o),
    .mask_q      (mask_q),
    .status_all  (status_all),
    .edge_stat_q (edge_stat_q),
    .edge_set    (edge_set)
);

// File: tb/tb_irq_collect_top.sv
// Bench for irq_collect_top: directed scenarios plus a behavioural
// reference model that is compared with the outputs on every clock.
module tb_irq_collect_top;

    localparam int NB  = 3;
    localparam int W   = 8;
    localparam int N   = NB * W;
    localparam int LVL = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic         rd_en = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   addr = '0;
    logic [7:0]   wdata = '0;
    logic [7:0]   rd_data;
    logic         irq_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    bit started = 1'b0;

    always #5 clk = ~clk;

    irq_collect_top dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rd_data (rd_data),
        .irq_o   (irq_o)
    );

    // Reference model state.
    logic [N-1:0] m_s1, m_s2, m_s3, m_lat, m_mask;
    logic         m_irq;
    logic [7:0]   m_rd;

    function automatic logic [7:0] m_status(input int b);
        logic [7:0] v;
        for (int j = 0; j < 8; j++) begin
            int i;
            i = b * 8 + j;
            v[j] = (i == LVL) ? m_s2[i] : m_lat[i];
        end
        return v;
    endfunction

    // Model update on every rising clock edge, from the old state.
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_s3 = '0; m_lat = '0; m_mask = '0;
            m_irq = 1'b0; m_rd = '0;
        end else begin
            logic [N-1:0] rise;
            bit pend;
            bit srd;
            rise = m_s2 & ~m_s3;
            srd  = rd_en && (addr < 3);
            pend = 1'b0;
            for (int b = 0; b < NB; b++)
                if ((m_status(b) & m_mask[b*8 +: 8]) != 0) pend = 1'b1;
            if (rd_en) begin
                if (addr < 3)      m_rd = m_status(int'(addr));
                else if (addr < 6) m_rd = m_mask[(int'(addr) - 3)*8 +: 8];
                else               m_rd = 8'h00;
            end
            m_irq = pend && !srd;
            for (int i = 0; i < N; i++) begin
                if (i != LVL) begin
                    bit clr;
                    clr = srd && (int'(addr) == i / 8);
                    m_lat[i] = (m_lat[i] && !clr) || (rise[i] && m_mask[i]);
                end
            end
            if (wr_en && addr >= 3 && addr < 6)
                m_mask[(int'(addr) - 3)*8 +: 8] = wdata;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = src;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Compare the outputs with the model between clock edges.
    always @(negedge clk) begin
        if (started && !done) begin
            chk(irq_o === m_irq, "R8 irq_o vs model", int'(irq_o), int'(m_irq));
            chk(rd_data === m_rd, "R2 rd_data vs model", int'(rd_data), int'(m_rd));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_rd(input logic [2:0] a, output logic [7:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic do_wr(input logic [2:0] a, input logic [7:0] v);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int i);
        src[i] = 1'b1; tick(3);
        src[i] = 1'b0; tick(3);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        int lfsr;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state
        chk(irq_o == 1'b0, "R1 irq after reset", int'(irq_o), 0);
        chk(rd_data == 8'h00, "R1 rd_data after reset", int'(rd_data), 0);
        for (int a = 3; a < 6; a++) begin
            do_rd(3'(a), d);
            chk(d == 8'h00, "R1 mask byte after reset", int'(d), 0);
        end

        // R4: edge while masked is dropped
        pulse(3);
        chk(irq_o == 1'b0, "R4 masked edge irq", int'(irq_o), 0);
        do_wr(3, 8'h08); tick(2);
        chk(irq_o == 1'b0, "R4 no irq after unmask", int'(irq_o), 0);
        do_rd(0, d);
        chk(d == 8'h00, "R4 status after unmask", int'(d), 0);

        // R3/R8: latch and interrupt latency
        src[3] = 1'b1; tick(3);
        chk(irq_o == 1'b0, "R8 irq before latency", int'(irq_o), 0);
        tick(1);
        chk(irq_o == 1'b1, "R8 irq after latency", int'(irq_o), 1);
        src[3] = 1'b0; tick(3);
        do_rd(0, d);
        chk(d == 8'h08, "R3 latched edge read", int'(d), 8'h08);
        do_rd(0, d);
        chk(d == 8'h00, "R5 cleared by read", int'(d), 0);
        tick(1);
        chk(irq_o == 1'b0, "R5 irq idle after clear", int'(irq_o), 0);

        // R2: mapping, readback, unused offsets
        do_wr(3, 8'hFF); do_wr(4, 8'hFF); do_wr(5, 8'hFF);
        do_rd(4, d);
        chk(d == 8'hFF, "R2 mask readback", int'(d), 8'hFF);
        do_wr(6, 8'h55);
        do_rd(6, d);
        chk(d == 8'h00, "R2 unused offset reads zero", int'(d), 0);
        do_rd(3, d);
        chk(d == 8'hFF, "R2 unused write ignored", int'(d), 8'hFF);
        pulse(10); pulse(17);
        do_rd(1, d);
        chk(d == 8'h04, "R2 source 10 at bank1 bit2", int'(d), 8'h04);
        do_rd(1, d);
        chk(d == 8'h00, "R5 bank1 cleared", int'(d), 0);
        do_rd(2, d);
        chk(d == 8'h02, "R5 bank2 kept", int'(d), 8'h02);

        // R9: drop after read while others pending
        pulse(0); pulse(9);
        do_rd(0, d);
        chk(d == 8'h01, "R9 bank0 read", int'(d), 8'h01);
        chk(irq_o == 1'b0, "R9 irq dropped", int'(irq_o), 0);
        tick(1);
        chk(irq_o == 1'b1, "R9 irq reasserted", int'(irq_o), 1);
        do_rd(1, d);
        tick(1);
        chk(irq_o == 1'b0, "R9 irq stays low when empty", int'(irq_o), 0);

        // R6: edge on the same clock as the read
        src[5] = 1'b1; tick(2);
        do_rd(0, d);
        chk(d == 8'h00, "R6 read before latch", int'(d), 0);
        do_rd(0, d);
        chk(d == 8'h20, "R6 coincident edge kept", int'(d), 8'h20);
        src[5] = 1'b0; tick(3);

        // R7: level source
        src[LVL] = 1'b1; tick(3);
        do_rd(1, d);
        chk(d == 8'h10, "R7 level visible", int'(d), 8'h10);
        do_rd(1, d);
        chk(d == 8'h10, "R7 level not cleared", int'(d), 8'h10);
        tick(1);
        chk(irq_o == 1'b1, "R7 level raises irq", int'(irq_o), 1);
        do_wr(4, 8'h00); tick(2);
        chk(irq_o == 1'b0, "R10 masked level no irq", int'(irq_o), 0);
        do_rd(1, d);
        chk(d == 8'h10, "R7 level shown while masked", int'(d), 8'h10);
        src[LVL] = 1'b0; tick(3);
        do_rd(1, d);
        chk(d == 8'h00, "R7 level follows input low", int'(d), 0);
        do_wr(4, 8'hFF);

        // R10: mask clear keeps latch
        pulse(20); tick(1);
        chk(irq_o == 1'b1, "R10 irq from source 20", int'(irq_o), 1);
        do_wr(5, 8'h00); tick(1);
        chk(irq_o == 1'b0, "R10 irq gone when masked", int'(irq_o), 0);
        do_wr(5, 8'hFF); tick(1);
        chk(irq_o == 1'b1, "R10 irq back when unmasked", int'(irq_o), 1);
        do_rd(2, d);
        chk(d == 8'h10, "R10 latch kept", int'(d), 8'h10);

        // Mixed pseudo-random phase, checked against the model each clock.
        lfsr = 32'h1ACE5;
        for (int c = 0; c < 600; c++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB4BCD35C : 0);
            if (lfsr[3:0] == 4'h0) src[lfsr[8:4] % N] = ~src[lfsr[8:4] % N];
            rd_en = (lfsr[11:9] == 3'b000);
            wr_en = (lfsr[14:12] == 3'b001);
            addr  = lfsr[17:15];
            wdata = lfsr[25:18];
            @(negedge clk);
        end
        rd_en = 1'b0; wr_en = 1'b0;
        tick(4);
        finish_run();
    end

endmodule